// File: doc/BRIEF.md
# Battery-Backed RAM Chip-Enable Controller

This block sits between a host's memory strobe and a bank of up to sixteen battery-backed static RAMs. An active-low master enable and a 4-bit bank address are decoded into sixteen active-low chip enables. Each enable is registered, so it follows its inputs one clock later. The block also watches two digital supply-low flags and two battery-low flags. These flags come from analog comparators outside the block. From them it write-protects the whole bank while the supply is out of tolerance, and it reports the failure on an active-low power-fail output.

An access already under way when the supply fails is never cut short. The granted enable stays frozen until the master enable returns high, and from then on every enable is forced high. When the supply returns, all enables stay high through a recovery window counted in clock cycles. At the end of that window the battery flags are sampled once. If both batteries are weak, the second memory cycle after power-up is suppressed. Software can detect the weak battery by writing a location and then reading it back.

Top module: `nvce_ctrl`

## Requirements
- R1: While decoding is allowed and `ce_n` is low, one clock after sampling exactly one output of `ram_ce_n` is low: bit `bank_addr` (bit 3 most significant, bit 0 least). Every other bit is high.
- R2: When `ce_n` is sampled high, every bit of `ram_ce_n` is high on the next clock, whatever the address.
- R3: While `ce_n` stays low during normal decoding, a new `bank_addr` moves the low output on the next clock. The address is not captured when the enable falls.
- R4: When a supply failure is seen while no enable output is low, every output goes high and stays high for as long as the failure lasts, even if `ce_n` goes low.
- R5: When a supply failure is seen while one enable output is low and `ce_n` is still low, that output vector stays frozen and ignores address changes. On the clock after `ce_n` is sampled high, all outputs go high, and they stay high while the failure lasts.
- R6: `pwr_fail_n` goes low three clocks after the selected supply-low flag rises: two synchronizer stages plus one output register. It returns high three clocks after the flag clears.
- R7: When `tol_sel` is 0, `sup_low_tight` is the failure condition. When `tol_sel` is 1, `sup_low_wide` is the failure condition. The flag that is not selected has no effect.
- R8: If both battery flags are sampled high at the end of the recovery window, the second `ce_n` low period after the window produces no enable output. The first and third periods and all later ones decode normally.
- R9: The battery counts as weak only when both `bat1_low` and `bat2_low` are high. With just one of them high, the second cycle decodes normally.
- R10: After reset, and after each supply failure clears, all outputs stay high for `REC_CYCLES` clocks of good supply. Decoding resumes on the clock after that. If the failure returns during the window, the count starts again from zero.
- R11: While `rst` is high, every bit of `ram_ce_n` is high and `pwr_fail_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; treated as a power-up |
| ce_n | input | 1 | Master chip enable, active low, synchronous to `clk` |
| bank_addr | input | ADDR_W (4) | Bank select, bit 3 most significant |
| sup_low_tight | input | 1 | Supply below the tighter threshold (asynchronous) |
| sup_low_wide | input | 1 | Supply below the wider threshold (asynchronous) |
| tol_sel | input | 1 | 0 selects the tight flag, 1 selects the wide flag; static |
| bat1_low | input | 1 | First battery below its minimum (asynchronous) |
| bat2_low | input | 1 | Second battery below its minimum (asynchronous) |
| ram_ce_n | output | 2**ADDR_W (16) | Registered RAM chip enables, active low |
| pwr_fail_n | output | 1 | Registered power-fail indication, active low |

## Verification
The assertions rely on a few assumptions about the inputs. `ce_n` and `bank_addr` must be synchronous to `clk`. `tol_sel` may change only while the supply is good. The wide flag is never raised without the tight flag, as two nested thresholds would behave. The stimulus changes every input only on falling clock edges and raises `sup_low_wide` only while `sup_low_tight` is already high. It also holds `ce_n` high across the end of each recovery window, so every counted memory cycle starts after decoding resumes.

// File: rtl/nvce_pkg.sv
package nvce_pkg;

    typedef enum logic [1:0] {
        PS_RECOVER = 2'd0,
        PS_RUN     = 2'd1,
        PS_FAIL    = 2'd2
    } pwr_state_t;

    typedef struct packed {
        logic low_tight;
        logic low_wide;
        logic bat1_low;
        logic bat2_low;
    } sense_t;

    localparam int unsigned SENSE_W = $bits(sense_t);

    function automatic logic supply_fail(input sense_t s, input logic tol_wide);
        return tol_wide ? s.low_wide : s.low_tight;
    endfunction

    function automatic logic battery_weak(input sense_t s);
        return s.bat1_low & s.bat2_low;
    endfunction

endpackage

// File: rtl/nvce_sync.sv
module nvce_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/nvce_pwr_seq.sv
module nvce_pwr_seq
    import nvce_pkg::*;
#(
    parameter int unsigned REC_CYCLES = 4_000_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fail_s,
    output pwr_state_t state,
    output logic       pf_n,
    output logic       rec_done
);
    localparam int unsigned CNT_W = (REC_CYCLES > 1) ? $clog2(REC_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(REC_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign rec_done = (state == PS_RECOVER) && !fail_s && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= PS_RECOVER;
            cnt   <= '0;
            pf_n  <= 1'b1;
        end else begin
            pf_n <= !fail_s;
            if (fail_s) begin
                state <= PS_FAIL;
                cnt   <= '0;
            end else begin
                unique case (state)
                    PS_FAIL: begin
                        state <= PS_RECOVER;
                        cnt   <= '0;
                    end
                    PS_RECOVER: begin
                        if (cnt == LAST) state <= PS_RUN;
                        else             cnt   <= cnt + 1'b1;
                    end
                    default: state <= PS_RUN;
                endcase
            end
        end
    end

    AST_PF_FOLLOWS_FAIL: assert property (@(posedge clk) disable iff (rst)
        fail_s |=> !pf_n); // R6

    AST_RUN_SUPPLY_GOOD: assert property (@(posedge clk) disable iff (rst)
        (state == PS_RUN) |-> pf_n); // R10
endmodule

// File: rtl/nvce_cycle_gate.sv
module nvce_cycle_gate
    import nvce_pkg::*;
#(
    parameter int unsigned BLOCK_NTH = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ce_n,
    input  pwr_state_t state,
    input  logic       rec_done,
    input  logic       bat_weak,
    output logic       blk
);
    localparam int unsigned CW = $clog2(BLOCK_NTH + 1);
    localparam logic [CW-1:0] SAT     = CW'(BLOCK_NTH);
    localparam logic [CW-1:0] BLK_IDX = CW'(BLOCK_NTH - 1);

    logic [CW-1:0] cyc;
    logic          weak_q;
    logic          ce_q;
    logic          low_seen;
    logic          in_run;
    logic          rise;

    assign in_run = (state == PS_RUN);
    assign rise   = ce_n && !ce_q;
    assign blk    = weak_q && in_run && (cyc == BLK_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc      <= '0;
            weak_q   <= 1'b0;
            ce_q     <= 1'b1;
            low_seen <= 1'b0;
        end else begin
            ce_q <= ce_n;
            if (rec_done) weak_q <= bat_weak;
            if (!in_run) begin
                cyc      <= '0;
                low_seen <= 1'b0;
            end else if (!ce_n) begin
                low_seen <= 1'b1;
            end else if (rise && low_seen) begin
                low_seen <= 1'b0;
                if (cyc != SAT) cyc <= cyc + 1'b1;
            end
        end
    end
endmodule

// File: rtl/nvce_decode.sv
module nvce_decode #(
    parameter int unsigned ADDR_W = 4,
    localparam int unsigned NB    = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              allow,
    output logic [NB-1:0]     ce_out_n
);
    logic live;
    logic hold;

    assign live = ~&ce_out_n;
    assign hold = !allow && live && !ce_n;

    for (genvar i = 0; i < NB; i++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst)        ce_out_n[i] <= 1'b1;
            else if (allow) ce_out_n[i] <= ce_n || (addr != ADDR_W'(i));
            else if (hold)  ce_out_n[i] <= ce_out_n[i];
            else            ce_out_n[i] <= 1'b1;
        end
    end

    AST_AT_MOST_ONE_LOW: assert property (@(posedge clk) disable iff (rst)
        $countones(~ce_out_n) <= 1); // R1

    AST_IDLE_ALL_HIGH: assert property (@(posedge clk) disable iff (rst)
        ce_n |=> (&ce_out_n)); // R2
endmodule

// File: rtl/nvce_ctrl.sv
module nvce_ctrl
    import nvce_pkg::*;
#(
    parameter int unsigned ADDR_W      = 4,
    parameter int unsigned REC_CYCLES  = 4_000_000,
    parameter int unsigned BLOCK_NTH   = 2,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned NB         = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic [ADDR_W-1:0] bank_addr,
    input  logic              sup_low_tight,
    input  logic              sup_low_wide,
    input  logic              tol_sel,
    input  logic              bat1_low,
    input  logic              bat2_low,
    output logic [NB-1:0]     ram_ce_n,
    output logic              pwr_fail_n
);
    sense_t           raw;
    sense_t           sns;
    logic [SENSE_W-1:0] sns_vec;
    logic             fail_s;
    pwr_state_t       state;
    logic             rec_done;
    logic             blk;
    logic             allow;

    assign raw = '{low_tight: sup_low_tight, low_wide: sup_low_wide,
                   bat1_low: bat1_low, bat2_low: bat2_low};

    nvce_sync #(.W(SENSE_W), .STAGES(SYNC_STAGES)) i_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (sns_vec)
    );

    assign sns    = sense_t'(sns_vec);
    assign fail_s = supply_fail(sns, tol_sel);

    nvce_pwr_seq #(.REC_CYCLES(REC_CYCLES)) i_pwr (
        .clk      (clk),
        .rst      (rst),
        .fail_s   (fail_s),
        .state    (state),
        .pf_n     (pwr_fail_n),
        .rec_done (rec_done)
    );

    nvce_cycle_gate #(.BLOCK_NTH(BLOCK_NTH)) i_gate (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .state    (state),
        .rec_done (rec_done),
        .bat_weak (battery_weak(sns)),
        .blk      (blk)
    );

    assign allow = (state == PS_RUN) && !blk;

    nvce_decode #(.ADDR_W(ADDR_W)) i_dec (
        .clk      (clk),
        .rst      (rst),
        .ce_n     (ce_n),
        .addr     (bank_addr),
        .allow    (allow),
        .ce_out_n (ram_ce_n)
    );

    AST_BLOCKED_CYCLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (blk && !ce_n) |=> (&ram_ce_n)); // R8

    AST_FAIL_NO_NEW_GRANT: assert property (@(posedge clk) disable iff (rst)
        ((state == PS_FAIL) && (&ram_ce_n)) |=> (&ram_ce_n)); // R4
endmodule

// File: tb/test_nvce_ctrl.sv
module test_nvce_ctrl;

    localparam int unsigned REC = 20;
    localparam logic [15:0] ALL = 16'hFFFF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce_n = 1'b1;
    logic [3:0]  bank_addr = '0;
    logic        sup_low_tight = 1'b0;
    logic        sup_low_wide = 1'b0;
    logic        tol_sel = 1'b0;
    logic        bat1_low = 1'b0;
    logic        bat2_low = 1'b0;
    logic [15:0] ram_ce_n;
    logic        pwr_fail_n;

    always #10 clk = ~clk;

    nvce_ctrl #(.REC_CYCLES(REC)) i_nvce_ctrl (
        .clk(clk), .rst(rst), .ce_n(ce_n), .bank_addr(bank_addr),
        .sup_low_tight(sup_low_tight), .sup_low_wide(sup_low_wide),
        .tol_sel(tol_sel), .bat1_low(bat1_low), .bat2_low(bat2_low),
        .ram_ce_n(ram_ce_n), .pwr_fail_n(pwr_fail_n)
    );

    typedef struct {
        int          due;
        logic [15:0] vec;
        bit          chk_pf;
        logic        pf;
        string       tag;
    } item_t;

    item_t q[$];
    int    cyc = 0;
    int    vectors = 0;
    int    fails = 0;
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [15:0] sel(input int i);
        return ~(16'h1 << i);
    endfunction

    // monitor: pop items that are due on this falling edge
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due == cyc) begin
            item_t it;
            it = q.pop_front();
            vectors++;
            if (ram_ce_n !== it.vec) begin
                fails++;
                $display("FAIL %s: ram_ce_n=%h expected %h", it.tag, ram_ce_n, it.vec);
            end
            if (it.chk_pf && pwr_fail_n !== it.pf) begin
                fails++;
                $display("FAIL %s: pwr_fail_n=%b expected %b", it.tag, pwr_fail_n, it.pf);
            end
        end
    end

    // driver: apply on a falling edge, result due on the next falling edge
    task automatic drv(input logic c, input logic [3:0] a, input bit chk,
                       input logic [15:0] ev, input bit cpf, input logic epf,
                       input string tag);
        @(negedge clk);
        ce_n = c;
        bank_addr = a;
        if (chk) begin
            item_t it;
            it.due = cyc + 1;
            it.vec = ev;
            it.chk_pf = cpf;
            it.pf = epf;
            it.tag = tag;
            q.push_back(it);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drv(1'b1, 4'd0, 1'b0, ALL, 1'b0, 1'b1, "");
    endtask

    // fail then return; leaves supply good, window elapsed, ce_n high
    task automatic power_cycle();
        sup_low_tight = 1'b1;
        idle(6);
        sup_low_tight = 1'b0;
        idle(REC + 8);
    endtask

    always @(posedge clk) begin
        if (cyc > 20000 && !done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog: cycle=%0d expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        // R11: reset state, even with the tight flag raised
        sup_low_tight = 1'b1;
        for (int i = 0; i < 3; i++) drv(1'b0, 4'd3, 1'b1, ALL, 1'b1, 1'b1, "R11");
        rst = 1'b0;
        sup_low_tight = 1'b0;

        // R10: recovery after reset keeps outputs high
        for (int i = 0; i < 5; i++) drv(1'b0, 4'd3, 1'b1, ALL, 1'b1, 1'b1, "R10");
        idle(REC + 5);

        // R1 + R3: walk every address while ce_n stays low
        for (int a = 0; a < 16; a++) drv(1'b0, 4'(a), 1'b1, sel(a), 1'b1, 1'b1, "R1");
        drv(1'b0, 4'd10, 1'b1, sel(10), 1'b0, 1'b1, "R3");
        drv(1'b0, 4'd11, 1'b1, sel(11), 1'b0, 1'b1, "R3");
        // R2
        drv(1'b1, 4'd7, 1'b1, ALL, 1'b0, 1'b1, "R2");
        drv(1'b1, 4'd0, 1'b1, ALL, 1'b0, 1'b1, "R2");
        idle(2);

        // R7: wide tolerance ignores the tight flag
        tol_sel = 1'b1;
        sup_low_tight = 1'b1;
        idle(5);
        drv(1'b0, 4'd4, 1'b1, sel(4), 1'b1, 1'b1, "R7");
        drv(1'b1, 4'd4, 1'b1, ALL, 1'b1, 1'b1, "R7");
        sup_low_wide = 1'b1;
        idle(4);
        drv(1'b0, 4'd4, 1'b1, ALL, 1'b1, 1'b0, "R7");
        drv(1'b1, 4'd4, 1'b0, ALL, 1'b0, 1'b1, "");
        sup_low_wide = 1'b0;
        sup_low_tight = 1'b0;
        idle(REC + 8);
        tol_sel = 1'b0;
        idle(3);

        // R4 + R6: failure with enable idle
        sup_low_tight = 1'b1;
        drv(1'b1, 4'd0, 1'b0, ALL, 1'b0, 1'b1, "");
        drv(1'b1, 4'd0, 1'b1, ALL, 1'b1, 1'b0, "R6");
        drv(1'b1, 4'd0, 1'b0, ALL, 1'b0, 1'b1, "");
        for (int i = 0; i < 3; i++) drv(1'b0, 4'd6, 1'b1, ALL, 1'b1, 1'b0, "R4");
        drv(1'b1, 4'd6, 1'b1, ALL, 1'b1, 1'b0, "R4");
        // R6 release + R10 exact window
        sup_low_tight = 1'b0;
        drv(1'b1, 4'd0, 1'b0, ALL, 1'b0, 1'b1, "");
        drv(1'b1, 4'd0, 1'b1, ALL, 1'b1, 1'b1, "R6");
        for (int k = 3; k <= 21; k++) drv(1'b1, 4'd0, 1'b0, ALL, 1'b0, 1'b1, "");
        drv(1'b0, 4'd1, 1'b1, ALL, 1'b0, 1'b1, "R10");
        drv(1'b0, 4'd1, 1'b1, sel(1), 1'b1, 1'b1, "R10");
        idle(3);

        // R5: in-flight access is frozen, then released
        drv(1'b0, 4'd9, 1'b1, sel(9), 1'b1, 1'b1, "R5");
        sup_low_tight = 1'b1;
        drv(1'b0, 4'd9, 1'b1, sel(9), 1'b0, 1'b1, "R5");
        drv(1'b0, 4'd9, 1'b1, sel(9), 1'b1, 1'b0, "R5");
        for (int k = 3; k <= 6; k++) drv(1'b0, 4'd2, 1'b1, sel(9), 1'b1, 1'b0, "R5");
        drv(1'b1, 4'd2, 1'b1, ALL, 1'b1, 1'b0, "R5");
        drv(1'b0, 4'd2, 1'b1, ALL, 1'b1, 1'b0, "R5");
        drv(1'b1, 4'd2, 1'b0, ALL, 1'b0, 1'b1, "");
        sup_low_tight = 1'b0;
        idle(REC + 8);

        // R10: failure pulse during the window restarts it
        sup_low_tight = 1'b1;
        idle(6);
        sup_low_tight = 1'b0;
        for (int k = 1; k <= 10; k++) drv(1'b1, 4'd0, 1'b0, ALL, 1'b0, 1'b1, "");
        sup_low_tight = 1'b1;
        drv(1'b1, 4'd0, 1'b0, ALL, 1'b0, 1'b1, "");
        sup_low_tight = 1'b0;
        for (int k = 12; k <= 23; k++) drv(1'b1, 4'd0, 1'b0, ALL, 1'b0, 1'b1, "");
        drv(1'b0, 4'd12, 1'b1, ALL, 1'b0, 1'b1, "R10");
        for (int k = 25; k <= 32; k++) drv(1'b1, 4'd0, 1'b0, ALL, 1'b0, 1'b1, "");
        drv(1'b0, 4'd12, 1'b1, ALL, 1'b0, 1'b1, "R10");
        drv(1'b0, 4'd12, 1'b1, sel(12), 1'b1, 1'b1, "R10");
        idle(3);

        // R8: both batteries weak, second cycle suppressed
        bat1_low = 1'b1;
        bat2_low = 1'b1;
        power_cycle();
        drv(1'b0, 4'd5, 1'b1, sel(5), 1'b0, 1'b1, "R8");
        drv(1'b1, 4'd5, 1'b1, ALL, 1'b0, 1'b1, "R8");
        drv(1'b0, 4'd5, 1'b1, ALL, 1'b0, 1'b1, "R8");
        drv(1'b0, 4'd6, 1'b1, ALL, 1'b0, 1'b1, "R8");
        drv(1'b1, 4'd6, 1'b1, ALL, 1'b0, 1'b1, "R8");
        drv(1'b0, 4'd5, 1'b1, sel(5), 1'b0, 1'b1, "R8");
        drv(1'b1, 4'd5, 1'b1, ALL, 1'b0, 1'b1, "R8");
        drv(1'b0, 4'd0, 1'b1, sel(0), 1'b0, 1'b1, "R8");
        idle(2);

        // R9: one good battery is enough
        bat2_low = 1'b0;
        power_cycle();
        drv(1'b0, 4'd14, 1'b1, sel(14), 1'b0, 1'b1, "R9");
        drv(1'b1, 4'd14, 1'b1, ALL, 1'b0, 1'b1, "R9");
        drv(1'b0, 4'd14, 1'b1, sel(14), 1'b0, 1'b1, "R9");
        drv(1'b1, 4'd14, 1'b1, ALL, 1'b0, 1'b1, "R9");
        bat1_low = 1'b0;
        idle(3);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule